// File: doc/BRIEF.md
# Keyed Memory Data-Line Scrambler

This block sits on the data path between a processor and its RAM, right in front of the memory. Every word the processor writes is reshuffled bit by bit and then XOR-masked before it reaches the RAM. Every word coming back is unmasked and put back in its original bit order, so the processor only ever sees plain data. Anyone probing the memory lines sees scrambled words, and the scrambling scheme is not fixed in the layout.

The scheme comes from an effective key. This key is the XOR of a fixed per-die identifier (for example fused serial-number bits) and a session value that software loads. The bit shuffle is a butterfly network of key-controlled two-input swap cells, so every key gives a valid one-to-one mapping. The XOR mask combines key bits with a fold of the word address, so equal data at different addresses looks different in memory.

Reloading the session key changes the scheme from the next cycle on. Data written under the earlier key is not recovered after that. The memory is taken to be a synchronous RAM with one cycle of read latency. A read is unscrambled with the key and address that were in force in the cycle the read was issued.

Top module: `keyed_bus_scrambler`

## Requirements
- R1: After reset the effective key is zero. No swap cell is crossed, so `mem_wdata` equals `cpu_wdata` XOR the folded address.
- R2: In the cycle of a write, `mem_wdata` = P(`cpu_wdata`) XOR M. P applies stages s = 0 .. log2(DW)-1 in order. In stage s the pairs (lo, lo+2^s), where bit s of lo is clear, are numbered p = 0,1,... in increasing lo order. Pair p is swapped when effective-key bit s*DW/2+p is 1.
- R3: In the cycle after an address is presented, `cpu_rdata` = P⁻¹(`mem_rdata` XOR M). P⁻¹ applies the same stages in reverse order. P⁻¹ and M use the key and address of the issuing cycle.
- R4: A word written at an address and read back under the same effective key returns the written value, for any key and any address.
- R5: When `key_load` is 1 at a clock edge, the effective key becomes `key_in` XOR `chip_uid` from the next cycle on. When `key_load` is 0, changes on `key_in` or `chip_uid` have no effect.
- R6: A read issued in the same cycle as `key_load` is unscrambled with the old key.
- R7: `mem_addr` and `mem_we` equal `cpu_addr` and `cpu_we` in the same cycle.
- R8: The same session value loaded with different `chip_uid` values gives different memory images. M = effective-key bits [NSW+DW-1:NSW] XOR the XOR of the DW-bit chunks of the zero-extended address, where NSW = log2(DW)*DW/2.
- R9: For a fixed key and address, the DW-bit write mapping is a bijection: all 2^DW inputs give distinct `mem_wdata` values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_uid | input | KW | Fixed per-die identifier |
| key_load | input | 1 | Load strobe for the session value |
| key_in | input | KW | Session value |
| cpu_addr | input | AW | Processor word address |
| cpu_we | input | 1 | Processor write enable |
| cpu_wdata | input | DW | Plain write data |
| cpu_rdata | output | DW | Plain read data, one cycle after the address |
| mem_addr | output | AW | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | DW | Scrambled write data |
| mem_rdata | input | DW | Scrambled read data from the RAM |

## Verification
The bench uses the defaults: DW=8, AW=8, KW=32 and the mask enabled. This gives 12 swap bits, 8 mask bits and 12 unused key bits. With an 8-bit word, the bench can sweep all 256 input values at one address to check the bijection directly. An 8-bit address lets a behavioural RAM and a shadow of the plain contents cover the whole space. Key changes are placed in the same cycle as outstanding reads, and the identifier is changed both with and without a reload.

// File: rtl/ksc_pkg.sv
package ksc_pkg;
  // Lower index of the p-th swap pair in a butterfly stage of span 2**s
  function automatic int pair_lo(input int p, input int s);
    return ((p >> s) << (s + 1)) | (p & ((1 << s) - 1));
  endfunction
endpackage

// File: rtl/ksc_swap_net.sv
module ksc_swap_net #(
  parameter int DW      = 8,
  parameter bit INVERSE = 1'b0,
  localparam int LG     = $clog2(DW),
  localparam int HALF   = DW / 2,
  localparam int NSW    = LG * HALF
) (
  input  logic [DW-1:0]  din,
  input  logic [NSW-1:0] ctl,
  output logic [DW-1:0]  dout
);
  logic [LG:0][DW-1:0] lvl;

  assign lvl[0] = din;

  for (genvar st = 0; st < LG; st++) begin : g_stage
    localparam int S = INVERSE ? (LG - 1 - st) : st;
    for (genvar p = 0; p < HALF; p++) begin : g_cell
      localparam int LO = ksc_pkg::pair_lo(p, S);
      localparam int HI = LO + (1 << S);
      assign lvl[st+1][LO] = ctl[S*HALF+p] ? lvl[st][HI] : lvl[st][LO];
      assign lvl[st+1][HI] = ctl[S*HALF+p] ? lvl[st][LO] : lvl[st][HI];
    end
  end

  assign dout = lvl[LG];
endmodule

// File: rtl/ksc_mask_gen.sv
module ksc_mask_gen #(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter bit MASK_EN = 1'b1,
  localparam int NCH    = (AW + DW - 1) / DW
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] seed,
  output logic [DW-1:0] mask
);
  if (MASK_EN) begin : g_mask
    logic [NCH*DW-1:0] addr_ext;
    assign addr_ext = (NCH*DW)'(addr);
    always_comb begin
      mask = seed;
      for (int i = 0; i < NCH; i++) begin
        mask = mask ^ addr_ext[i*DW +: DW];
      end
    end
  end else begin : g_nomask
    logic unused_in;
    assign unused_in = ^{addr, seed};
    assign mask = '0;
  end
endmodule

// File: rtl/ksc_key_reg.sv
module ksc_key_reg #(
  parameter int KW  = 32,
  parameter int NSW = 12,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [KW-1:0]  key_in,
  input  logic [KW-1:0]  uid,
  output logic [NSW-1:0] ctl,
  output logic [DW-1:0]  seed
);
  logic [KW-1:0] eff_q, eff_d;
  logic          eff_en;
  logic          unused_key;

  always_comb begin
    eff_en = load;
    eff_d  = key_in ^ uid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      eff_q <= '0;
    else if (eff_en) eff_q <= eff_d;
  end

  assign ctl        = eff_q[NSW-1:0];
  assign seed       = eff_q[NSW +: DW];
  assign unused_key = ^eff_q;

  AST_KEY_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (eff_q == $past(key_in ^ uid)));  // R5
  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(eff_q));  // R5
endmodule

// File: rtl/keyed_bus_scrambler.sv
module keyed_bus_scrambler #(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int KW      = 32,
  parameter bit MASK_EN = 1'b1,
  localparam int NSW    = $clog2(DW) * (DW / 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [KW-1:0] chip_uid,
  input  logic          key_load,
  input  logic [KW-1:0] key_in,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_we,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // Effective key
  logic [NSW-1:0] key_ctl;
  logic [DW-1:0]  key_seed;

  ksc_key_reg #(.KW(KW), .NSW(NSW), .DW(DW)) u_key (
    .clk(clk), .rst_n(rst_n_s), .load(key_load), .key_in(key_in),
    .uid(chip_uid), .ctl(key_ctl), .seed(key_seed)
  );

  // Write path: shuffle then mask
  logic [DW-1:0] wr_mask, wr_perm;

  ksc_mask_gen #(.AW(AW), .DW(DW), .MASK_EN(MASK_EN)) u_wmask (
    .addr(cpu_addr), .seed(key_seed), .mask(wr_mask)
  );
  ksc_swap_net #(.DW(DW), .INVERSE(1'b0)) u_fwd (
    .din(cpu_wdata), .ctl(key_ctl), .dout(wr_perm)
  );

  assign mem_wdata = wr_perm ^ wr_mask;
  assign mem_addr  = cpu_addr;
  assign mem_we    = cpu_we;

  // Read context held for the cycle in which the RAM answers
  logic [NSW-1:0] ctl_q, ctl_d;
  logic [DW-1:0]  mask_q, mask_d;

  always_comb begin
    ctl_d  = key_ctl;
    mask_d = wr_mask;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctl_q  <= '0;
      mask_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      mask_q <= mask_d;
    end
  end

  // Read path: unmask then unshuffle
  logic [DW-1:0] rd_unmasked;
  assign rd_unmasked = mem_rdata ^ mask_q;

  ksc_swap_net #(.DW(DW), .INVERSE(1'b1)) u_inv (
    .din(rd_unmasked), .ctl(ctl_q), .dout(cpu_rdata)
  );

  AST_WR_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n_s)
    $countones(mem_wdata ^ wr_mask) == $countones(cpu_wdata));  // R2
  AST_RD_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n_s)
    $countones(cpu_rdata) == $countones(mem_rdata ^ mask_q));  // R3
  AST_RD_CTX: assert property (@(posedge clk) disable iff (!rst_n_s)
    key_load |=> (ctl_q == $past(key_ctl)));  // R6
endmodule

// File: tb/keyed_bus_scrambler_test.sv
`timescale 1ns/1ps
module keyed_bus_scrambler_test;
  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int KW  = 32;
  localparam int LG  = 3;
  localparam int NSW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [KW-1:0] chip_uid, key_in;
  logic          key_load, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_we;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  keyed_bus_scrambler uut (
    .clk(clk), .rst_n(rst_n), .chip_uid(chip_uid), .key_load(key_load),
    .key_in(key_in), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Behavioural synchronous RAM, read before write
  logic [DW-1:0] ram [256];
  logic [DW-1:0] rd_q;
  assign mem_rdata = rd_q;
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    rd_q <= ram[mem_addr];
  end

  // Reference model state
  logic [KW-1:0] mkey, pkey;
  logic [AW-1:0] paddr;
  logic [DW-1:0] sh_val [256];
  int            sh_ep  [256];
  int            epoch;
  bit            p_ok;
  logic [DW-1:0] p_val;
  string         p_tag;

  function automatic logic [DW-1:0] m_perm(input logic [DW-1:0] d,
                                           input logic [NSW-1:0] c, input bit inv);
    logic [DW-1:0] v;
    v = d;
    for (int k = 0; k < LG; k++) begin
      int s;
      int p;
      s = inv ? (LG - 1 - k) : k;
      p = 0;
      for (int lo = 0; lo < DW; lo++) begin
        if (((lo >> s) & 1) == 0) begin
          if (c[s*(DW/2)+p]) begin
            logic t;
            t = v[lo];
            v[lo] = v[lo + (1 << s)];
            v[lo + (1 << s)] = t;
          end
          p++;
        end
      end
    end
    return v;
  endfunction

  function automatic logic [DW-1:0] m_mask(input logic [KW-1:0] k, input logic [AW-1:0] a);
    logic [DW-1:0] m;
    m = k[NSW +: DW];
    for (int i = 0; i < AW; i += DW) m ^= DW'(a >> i);
    return m;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input bit kl, input logic [KW-1:0] kin);
    logic [DW-1:0] ew, er;
    @(negedge clk);
    cpu_we = we; cpu_addr = a; cpu_wdata = wd; key_load = kl; key_in = kin;
    #1;
    ew = m_perm(wd, mkey[NSW-1:0], 1'b0) ^ m_mask(mkey, a);
    chk(mem_wdata === ew, "R2 write image", mem_wdata, ew);
    chk(mem_addr === a && mem_we === we, "R7 address/enable pass", mem_addr, a);
    er = m_perm(mem_rdata ^ m_mask(pkey, paddr), pkey[NSW-1:0], 1'b1);
    chk(cpu_rdata === er, "R3 read unscramble", cpu_rdata, er);
    if (p_ok) chk(cpu_rdata === p_val, p_tag, cpu_rdata, p_val);
    // advance model across the coming edge
    pkey  = mkey;
    paddr = a;
    p_ok  = (sh_ep[a] == epoch);
    p_val = sh_val[a];
    p_tag = kl ? "R6 read in rekey cycle" : "R4 round trip";
    if (we) begin sh_val[a] = wd; sh_ep[a] = epoch; end
    if (kl) begin mkey = kin ^ chip_uid; epoch++; end
  endtask

  bit            seen [256];
  logic [DW-1:0] img_a, img_b;
  bit            dup;

  initial begin
    for (int i = 0; i < 256; i++) begin ram[i] = '0; sh_ep[i] = -1; sh_val[i] = '0; end
    rd_q = '0;
    rst_n = 1'b0; chip_uid = 32'h6B1D_93C5; key_in = '0; key_load = 1'b0;
    cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    mkey = '0; pkey = '0; paddr = '0; epoch = 0; p_ok = 1'b0; p_val = '0; p_tag = "";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset key gives pure address mask
    step(1'b1, 8'h35, 8'hC4, 1'b0, '0);
    chk(mem_wdata === (8'hC4 ^ 8'h35), "R1 reset identity shuffle", mem_wdata, 8'hC4 ^ 8'h35);
    step(1'b1, 8'h36, 8'h5E, 1'b0, '0);
    // R6: read 0x35 in the same cycle as a key load
    step(1'b0, 8'h35, 8'h00, 1'b1, 32'h2F47_A9D0);
    step(1'b0, 8'h36, 8'h00, 1'b0, '0);
    step(1'b0, 8'h00, 8'h00, 1'b0, '0);

    // R4: several data patterns under the new key
    for (int i = 0; i < 8; i++) step(1'b1, AW'(8'h10 + i), DW'(1 << i), 1'b0, '0);
    for (int i = 0; i < 8; i++) step(1'b0, AW'(8'h10 + i), 8'h00, 1'b0, '0);
    for (int i = 0; i < 32; i++) step(1'b1, AW'(i * 7), DW'(i * 37 + 11), 1'b0, '0);
    for (int i = 0; i < 32; i++) step(1'b0, AW'(i * 7), 8'h00, 1'b0, '0);
    step(1'b1, 8'hFF, 8'hFF, 1'b0, '0);
    step(1'b1, 8'h00, 8'h00, 1'b0, '0);
    step(1'b0, 8'hFF, 8'h00, 1'b0, '0);
    step(1'b0, 8'h00, 8'h00, 1'b0, '0);
    step(1'b0, 8'h00, 8'h00, 1'b0, '0);

    // R9: exhaustive bijection at one address
    dup = 1'b0;
    for (int i = 0; i < 256; i++) seen[i] = 1'b0;
    for (int v = 0; v < 256; v++) begin
      step(1'b0, 8'h5A, DW'(v), 1'b0, '0);
      if (seen[mem_wdata]) dup = 1'b1;
      seen[mem_wdata] = 1'b1;
    end
    chk(!dup, "R9 bijection over all inputs", {7'b0, dup}, 8'h00);

    // R5: identifier and key_in changes without a load are ignored
    step(1'b1, 8'h40, 8'h96, 1'b0, 32'hFFFF_FFFF);
    img_a = mem_wdata;
    chip_uid = 32'h6B1D_93C5 ^ 32'h000F_F000;
    step(1'b1, 8'h40, 8'h96, 1'b0, 32'h1234_5678);
    chk(mem_wdata === img_a, "R5 no effect without load", mem_wdata, img_a);
    step(1'b0, 8'h40, 8'h00, 1'b0, '0);
    step(1'b0, 8'h00, 8'h00, 1'b0, '0);

    // R8: reload the same session value under the changed identifier
    step(1'b0, 8'h00, 8'h00, 1'b1, 32'h2F47_A9D0);
    step(1'b1, 8'h40, 8'h96, 1'b0, '0);
    img_b = mem_wdata;
    chk(img_b !== img_a, "R8 identifier changes image", img_b, img_a);
    step(1'b0, 8'h40, 8'h00, 1'b0, '0);
    step(1'b0, 8'h10, 8'h00, 1'b0, '0);
    step(1'b0, 8'h00, 8'h00, 1'b0, '0);

    // Back-to-back rekeys with writes and reads around them
    for (int i = 0; i < 6; i++) begin
      step(1'b1, AW'(8'h80 + i), DW'(8'hA0 ^ i), 1'b0, '0);
      step(1'b0, AW'(8'h80 + i), 8'h00, 1'b1, KW'(32'h0BAD_F00D * (i + 3)));
      step(1'b1, AW'(8'h90 + i), DW'(8'h3C + i), 1'b0, '0);
      step(1'b0, AW'(8'h90 + i), 8'h00, 1'b0, '0);
      step(1'b0, 8'h00, 8'h00, 1'b0, '0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule